// File: doc/BRIEF.md
# Multihop Path Request Generator

This block sits on one output port of a mesh router that acts as the starting point of a multihop path. Each cycle it chooses one flit that wants this output and drives a path-setup request on dedicated control wires. Those wires fan out to the routers that lie up to `HOP_MAX` hops downstream. The request carries three fields: the number of hops the flit asks to travel in the next cycle, a flag saying the stop router is the flit's final destination, and the flit's virtual-network number. Alongside the request the block raises a one-hot grant toward the input buffer whose flit was chosen.

Requests have two sources. The normal source is local allocation among buffered head flits. A round-robin pointer picks the winner, the winner is registered on the clock edge, and its request appears during the following cycle. The second source is a low-load shortcut. A flit arriving at an empty network input port can issue its request in the same cycle it arrives, but only when no registered winner holds the output. The flit is still written into its buffer, and that write happens outside this block. Flits from the core port always go through allocation. The pointer advances only when the downstream logic reports that the granted flit left.

Top module: `mhop_req_gen`

## Requirements
- R1: The request length field is clog2(HOP_MAX+1) bits wide and carries min(HOP_MAX, hops remaining) of the chosen flit; it is nonzero whenever a grant is raised.
- R2: The ejection flag is 1 exactly when the chosen flit's remaining hop count is at most HOP_MAX, so the requested stop is its destination.
- R3: The request's vnet field equals the vnet input of the chosen port.
- R4: A buffered candidate sampled on a clock edge drives its request and grant during the cycle after that edge; before the edge the outputs still show the previous choice.
- R5: Among buffered candidates, the winner is the first valid port found scanning upward (wrapping) from the pointer value that applies at that edge.
- R6: The pointer moves to (granted port + 1) mod N_PORTS on an edge where `depart` is high while a registered grant is shown, and that new value already steers the selection made at the same edge; otherwise it holds. It resets to 0.
- R7: With no registered winner, a flit on `new_valid[i]` at a network port (i ≥ 1) whose `port_idle[i]` is 1 drives its request and grant in the same cycle; among several such ports the lowest index wins.
- R8: Port 0 is the core port and never uses the same-cycle path; an arrival on a port with `port_idle` low also never uses it.
- R9: A registered allocation winner takes precedence over any same-cycle arrival.
- R10: The grant is one-hot or zero, and when there is no grant, all request outputs are zero (including during and right after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| held_valid | input | N_PORTS | Buffered head flit at port i wants this output |
| held_hops | input | N_PORTS*HOPW | Remaining hops per buffered candidate, port i at bits i*HOPW |
| held_vnet | input | N_PORTS*VNW | Virtual network per buffered candidate |
| new_valid | input | N_PORTS | Flit arriving this cycle at port i wants this output |
| new_hops | input | N_PORTS*HOPW | Remaining hops per arriving flit |
| new_vnet | input | N_PORTS*VNW | Virtual network per arriving flit |
| port_idle | input | N_PORTS | Input buffer of port i is empty |
| depart | input | 1 | The currently granted flit leaves this cycle |
| req_hops | output | REQW | Requested hop count, 0 means no request |
| req_eject | output | 1 | Requested stop router is the destination |
| req_vnet | output | VNW | Virtual network of the requesting flit |
| grant | output | N_PORTS | One-hot grant to the chosen input |

## Verification
The properties assume two things about the inputs. Every valid candidate carries a remaining hop count of at least one. The upstream logic raises `depart` only while a grant is shown. The bench keeps every hop value in the range 1 to 15 and lets the reference model ignore `depart` in cycles without a grant, which matches the design's rule. Candidate masks, departure patterns and arrival sets are swept: the hop encoding exhaustively for each vnet, the pointer from a pseudo-random sequence, and the same-cycle path through its eligible and ineligible combinations.

// File: rtl/mhop_pkg.sv
package mhop_pkg;
  // Which path currently owns the request wires.
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_ALLOC = 2'd1,
    SRC_FAST  = 2'd2
  } req_src_e;
endpackage

// File: rtl/mhop_rr_pick.sv
// Cyclic first-valid search starting at a pointer.
module mhop_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    int j;
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      j = int'(start) + k;
      if (j >= N) j = j - N;
      if (cand[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/mhop_hop_enc.sv
// Clamps a remaining hop count to the per-cycle reach and flags a final leg.
module mhop_hop_enc #(
  parameter int HOPW    = 4,
  parameter int HOP_MAX = 3,
  parameter int REQW    = 2
) (
  input  logic [HOPW-1:0] hops,
  output logic [REQW-1:0] len,
  output logic            last_leg
);
  localparam logic [HOPW-1:0] REACH = HOPW'(HOP_MAX);

  always_comb begin
    if (hops > REACH) begin
      len      = REQW'(HOP_MAX);
      last_leg = 1'b0;
    end else begin
      len      = REQW'(hops);
      last_leg = (hops != '0);
    end
  end
endmodule

// File: rtl/mhop_req_gen.sv
module mhop_req_gen
  import mhop_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int HOP_MAX = 3,
  parameter int HOPW    = 4,
  parameter int N_VNET  = 2,
  localparam int REQW   = $clog2(HOP_MAX + 1),
  localparam int VNW    = (N_VNET > 1) ? $clog2(N_VNET) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        held_valid,
  input  logic [N_PORTS*HOPW-1:0]   held_hops,
  input  logic [N_PORTS*VNW-1:0]    held_vnet,
  input  logic [N_PORTS-1:0]        new_valid,
  input  logic [N_PORTS*HOPW-1:0]   new_hops,
  input  logic [N_PORTS*VNW-1:0]    new_vnet,
  input  logic [N_PORTS-1:0]        port_idle,
  input  logic                      depart,
  output logic [REQW-1:0]           req_hops,
  output logic                      req_eject,
  output logic [VNW-1:0]            req_vnet,
  output logic [N_PORTS-1:0]        grant
);
  localparam int IW = $clog2(N_PORTS);
  localparam logic [N_PORTS-1:0] CORE_BIT = N_PORTS'(1);
  localparam logic [IW-1:0]      LAST_IDX = IW'(N_PORTS - 1);
  localparam logic [REQW-1:0]    REACH_R  = REQW'(HOP_MAX);

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rsync_q;
  logic       rst_lcl_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_lcl_n = rsync_q[1];

  // ---------------- unpack per-port fields ----------------
  logic [HOPW-1:0] held_hops_a [N_PORTS];
  logic [VNW-1:0]  held_vnet_a [N_PORTS];
  logic [HOPW-1:0] new_hops_a  [N_PORTS];
  logic [VNW-1:0]  new_vnet_a  [N_PORTS];
  for (genvar g = 0; g < N_PORTS; g++) begin : g_unpack
    assign held_hops_a[g] = held_hops[g*HOPW +: HOPW];
    assign held_vnet_a[g] = held_vnet[g*VNW  +: VNW];
    assign new_hops_a[g]  = new_hops[g*HOPW  +: HOPW];
    assign new_vnet_a[g]  = new_vnet[g*VNW   +: VNW];
  end

  // ---------------- registered state ----------------
  logic            win_vld_q, win_vld_d;
  logic [IW-1:0]   win_idx_q, win_idx_d;
  logic [REQW-1:0] win_len_q, win_len_d;
  logic            win_ej_q,  win_ej_d;
  logic [VNW-1:0]  win_vn_q,  win_vn_d;
  logic [IW-1:0]   ptr_q, ptr_d, ptr_nx;
  logic            ptr_adv;

  // Pointer: moves past the granted port when it departs.
  assign ptr_adv = depart & win_vld_q;
  assign ptr_nx  = (win_idx_q == LAST_IDX) ? '0 : win_idx_q + IW'(1);
  assign ptr_d   = ptr_adv ? ptr_nx : ptr_q;

  // ---------------- local allocation ----------------
  logic            alloc_found;
  logic [IW-1:0]   alloc_idx;
  logic [REQW-1:0] alloc_len;
  logic            alloc_ej;

  mhop_rr_pick #(.N(N_PORTS), .IW(IW)) u_alloc_pick (
    .cand  (held_valid),
    .start (ptr_d),
    .found (alloc_found),
    .idx   (alloc_idx)
  );

  mhop_hop_enc #(.HOPW(HOPW), .HOP_MAX(HOP_MAX), .REQW(REQW)) u_alloc_enc (
    .hops     (held_hops_a[alloc_idx]),
    .len      (alloc_len),
    .last_leg (alloc_ej)
  );

  always_comb begin
    win_vld_d = alloc_found;
    win_idx_d = alloc_found ? alloc_idx : '0;
    win_len_d = alloc_found ? alloc_len : '0;
    win_ej_d  = alloc_found & alloc_ej;
    win_vn_d  = alloc_found ? held_vnet_a[alloc_idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_lcl_n) begin
    if (!rst_lcl_n) begin
      win_vld_q <= 1'b0;
      win_idx_q <= '0;
      win_len_q <= '0;
      win_ej_q  <= 1'b0;
      win_vn_q  <= '0;
      ptr_q     <= '0;
    end else begin
      win_vld_q <= win_vld_d;
      win_idx_q <= win_idx_d;
      win_len_q <= win_len_d;
      win_ej_q  <= win_ej_d;
      win_vn_q  <= win_vn_d;
      if (ptr_adv) ptr_q <= ptr_nx;
    end
  end

  // ---------------- same-cycle path for idle network ports ----------------
  logic [N_PORTS-1:0] fast_cand;
  logic               fast_found;
  logic [IW-1:0]      fast_idx;
  logic [REQW-1:0]    fast_len;
  logic               fast_ej;

  assign fast_cand = new_valid & port_idle & ~CORE_BIT;

  mhop_rr_pick #(.N(N_PORTS), .IW(IW)) u_fast_pick (
    .cand  (fast_cand),
    .start ('0),
    .found (fast_found),
    .idx   (fast_idx)
  );

  mhop_hop_enc #(.HOPW(HOPW), .HOP_MAX(HOP_MAX), .REQW(REQW)) u_fast_enc (
    .hops     (new_hops_a[fast_idx]),
    .len      (fast_len),
    .last_leg (fast_ej)
  );

  // ---------------- output selection ----------------
  req_src_e src;
  always_comb begin
    if (win_vld_q)       src = SRC_ALLOC;
    else if (fast_found) src = SRC_FAST;
    else                 src = SRC_NONE;
  end

  always_comb begin
    req_hops  = '0;
    req_eject = 1'b0;
    req_vnet  = '0;
    grant     = '0;
    unique case (src)
      SRC_ALLOC: begin
        req_hops  = win_len_q;
        req_eject = win_ej_q;
        req_vnet  = win_vn_q;
        grant     = N_PORTS'(1) << win_idx_q;
      end
      SRC_FAST: begin
        req_hops  = fast_len;
        req_eject = fast_ej;
        req_vnet  = new_vnet_a[fast_idx];
        grant     = N_PORTS'(1) << fast_idx;
      end
      default: ;
    endcase
  end

  // ---------------- assertions ----------------
  // R10: at most one input granted
  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_lcl_n)
    $onehot0(grant));

  // R10: request wires are quiet without a grant
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_lcl_n)
    (grant == '0) |-> (req_hops == '0 && !req_eject && req_vnet == '0));

  // R1: a granted request asks for 1..HOP_MAX hops
  p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_lcl_n)
    (grant != '0) |-> (req_hops != '0 && req_hops <= REACH_R));

  // R8: core port is granted only after it was a buffered candidate
  p_core_buffered_r8: assert property (@(posedge clk) disable iff (!rst_lcl_n)
    grant[0] |-> $past(held_valid[0]));

  // R6: without a departure the pointer holds
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_lcl_n)
    !depart |=> $stable(ptr_q));

  // R2: the destination flag only rides on a real request
  p_eject_granted_r2: assert property (@(posedge clk) disable iff (!rst_lcl_n)
    req_eject |-> (grant != '0));
endmodule

// File: tb/mhop_req_gen_bench.sv
`timescale 1ns/1ps
module mhop_req_gen_bench;
  localparam int N = 4;
  localparam int HM = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  held_valid, new_valid, port_idle, grant;
  logic [15:0] held_hops, new_hops;
  logic [3:0]  held_vnet, new_vnet;
  logic        depart;
  logic [1:0]  req_hops;
  logic        req_eject;
  logic [0:0]  req_vnet;

  int bh [4];
  int bv [4];
  int ah [4];
  int av [4];

  int errors = 0;
  int checks = 0;
  int mptr = 0;
  int mw = -1;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      held_hops[i*4 +: 4] = 4'(bh[i]);
      held_vnet[i]        = bv[i][0];
      new_hops[i*4 +: 4]  = 4'(ah[i]);
      new_vnet[i]         = av[i][0];
    end
  end

  mhop_req_gen u_mhop_req_gen (
    .clk(clk), .rst_n(rst_n),
    .held_valid(held_valid), .held_hops(held_hops), .held_vnet(held_vnet),
    .new_valid(new_valid), .new_hops(new_hops), .new_vnet(new_vnet),
    .port_idle(port_idle), .depart(depart),
    .req_hops(req_hops), .req_eject(req_eject), .req_vnet(req_vnet),
    .grant(grant)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pick(input int m, input int p);
    for (int k = 0; k < 4; k++) begin
      if (m[(p + k) % 4]) return (p + k) % 4;
    end
    return -1;
  endfunction

  function automatic int clampv(input int h);
    return (h > HM) ? HM : h;
  endfunction

  // Compare outputs against the registered-winner model.
  task automatic expect_reg(input string tag);
    if (mw < 0) begin
      chk({tag, " R10 grant"}, grant, 0);
      chk({tag, " R10 hops"}, req_hops, 0);
      chk({tag, " R10 eject"}, req_eject, 0);
      chk({tag, " R10 vnet"}, req_vnet, 0);
    end else begin
      chk({tag, " grant"}, grant, 1 << mw);
      chk({tag, " R1 hops"}, req_hops, clampv(bh[mw]));
      chk({tag, " R2 eject"}, req_eject, (bh[mw] <= HM) ? 1 : 0);
      chk({tag, " R3 vnet"}, req_vnet, bv[mw]);
    end
  endtask

  // One cycle of allocation stimulus, called at a falling edge.
  task automatic cyc(input int m, input bit d, input string tag);
    int pd;
    held_valid = 4'(m);
    depart = d;
    if (new_valid == 4'b0) begin
      #1;
      chk({tag, " R4 before edge"}, grant, (mw < 0) ? 0 : (1 << mw));
    end
    pd = (d && mw >= 0) ? (mw + 1) % 4 : mptr;
    mptr = pd;
    mw = pick(m, pd);
    @(posedge clk);
    @(negedge clk);
    expect_reg(tag);
  endtask

  task automatic fast(input int arr, input int idle, input int eg, input int eh,
                      input int ee, input int ev, input string tag);
    new_valid = 4'(arr);
    port_idle = 4'(idle);
    #1;
    chk({tag, " grant"}, grant, eg);
    chk({tag, " hops"}, req_hops, eh);
    chk({tag, " eject"}, req_eject, ee);
    chk({tag, " vnet"}, req_vnet, ev);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 4; i++) begin
      bh[i] = 1; bv[i] = 0; ah[i] = 1; av[i] = 0;
    end
    rst_n = 1'b0;
    held_valid = '0; new_valid = '0; port_idle = '0; depart = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset grant", grant, 0);
    chk("R10 reset hops", req_hops, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 after reset grant", grant, 0);
    chk("R10 after reset eject", req_eject, 0);

    // R1 R2 R3: encoding sweep over every hop count and vnet.
    for (int h = 1; h < 16; h++) begin
      for (int v = 0; v < 2; v++) begin
        bh[h % 4] = h;
        bv[h % 4] = v;
        cyc(1 << (h % 4), 1'b0, "R1 sweep");
        cyc(0, 1'b0, "R10 clear");
      end
    end

    // R5 R6: all ports valid, depart every cycle gives a rotating order.
    for (int i = 0; i < 4; i++) begin
      bh[i] = i + 1;
      bv[i] = i % 2;
    end
    for (int k = 0; k < 8; k++) cyc(15, 1'b1, "R6 rotate");
    // R6: no departure keeps the same winner.
    for (int k = 0; k < 4; k++) cyc(15, 1'b0, "R6 hold");
    // R5: pseudo-random masks and departures.
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(int'(lfsr[3:0]), lfsr[7], "R5 random");
    end
    cyc(0, 1'b0, "R10 drain");
    cyc(0, 1'b0, "R10 drain");

    // R7: same-cycle path.
    ah[1] = 5; av[1] = 1; ah[2] = 2; av[2] = 0; ah[3] = 1; av[3] = 1; ah[0] = 2;
    fast(4'b0010, 4'b1111, 4'b0010, 3, 0, 1, "R7 single");
    fast(4'b0110, 4'b1111, 4'b0010, 3, 0, 1, "R7 lowest");
    fast(4'b0100, 4'b1111, 4'b0100, 2, 1, 0, "R7 short eject");
    fast(4'b1000, 4'b1111, 4'b1000, 1, 1, 1, "R7 port3");
    fast(4'b0110, 4'b1101, 4'b0100, 2, 1, 0, "R8 busy port skipped");
    // R8: core port and non-idle ports never shortcut.
    fast(4'b0001, 4'b1111, 0, 0, 0, 0, "R8 core");
    fast(4'b0100, 4'b1011, 0, 0, 0, 0, "R8 not idle");
    fast(4'b1111, 4'b0001, 0, 0, 0, 0, "R8 only core idle");

    // R9: registered winner beats an arrival.
    new_valid = 4'b1000;
    port_idle = 4'b1111;
    cyc(1, 1'b0, "R9 priority");
    new_valid = 4'b0;
    cyc(0, 1'b0, "R10 final clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule